// File: doc/BRIEF.md
# Manchester II Framed Word Transmitter

This block accepts a parallel data word through a single-cycle load strobe. It sends the word on one serial line as a complete Manchester II frame. A frame starts with a sync pulse three bit times long. The data bits follow, most significant first. A single odd-parity bit closes the frame. One input chooses the polarity of the sync pulse at load time: either a command/status sync or a data sync.

The block is paced by a half-bit enable pulse that the surrounding logic supplies. No oversampling clock is involved. Each bit time is two half-bit phases. A busy flag covers the whole frame, and a one-cycle done pulse marks its end. The only input shared with any receive logic is a master reset, which aborts a frame at any point.

Top module: `manch_frame_tx`

## Requirements
- R1: After master reset, and whenever busy is low, the serial line is low. Busy and done are low after reset.
- R2: A load while idle raises busy on the next clock. The line stays low until the first half-bit enable after the load, and that enable starts half 0 of the frame.
- R3: With the sync select at 1 (command/status sync), halves 0 to 2 of the frame are high and halves 3 to 5 are low.
- R4: With the sync select at 0 (data sync), halves 0 to 2 are low and halves 3 to 5 are high.
- R5: Data bits follow the sync, most significant bit first, two halves each. A 1 is sent high then low, and a 0 is sent low then high.
- R6: The last bit is odd parity over the data word: the total count of ones in data plus parity is odd. It is encoded like a data bit.
- R7: The frame lasts 2*(3+DATA_W+1) halves. The enable that ends the last parity half drops busy and raises done for exactly one clock.
- R8: A load while busy is ignored. The frame in progress keeps its word and its sync type.
- R9: Every data and parity bit has a transition at its middle.
- R10: Without a half-bit enable, the line and busy hold their values.
- R11: A master reset during a frame returns the line low and busy low at once. The next load starts a clean frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| master_rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | Half-bit-time enable, one clock wide |
| load | input | 1 | Word load strobe |
| data_in | input | DATA_W | Word to send |
| sync_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| line | output | 1 | Serial Manchester II output |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at the end of a frame |

## Verification
Two situations are hard to reach from the ports. The first is a load strobe that arrives in the middle of a frame. The bench makes one between two half-bit enables, during the data field. It uses a different word and the opposite sync type, and then checks every remaining half against the first word. The second is a reset that arrives mid-frame. The bench drives one after a dozen halves, then checks that the line is idle and that a new frame is clean. A long stretch with no enable during the data field shows that the line holds its value.

// File: rtl/manch_frame_tx.sv
module manch_frame_tx #(
  parameter int DATA_W      = 16,
  parameter int SYNC_HALVES = 3
) (
  input  logic              clk,
  input  logic              master_rst,
  input  logic              half_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              sync_cmd,
  output logic              line,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_HALVES = 2 * SYNC_HALVES + 2 * DATA_W + 2;
  localparam int IDX_W        = $clog2(FRAME_HALVES);
  localparam logic [IDX_W-1:0] SYNC_MID  = IDX_W'(SYNC_HALVES);
  localparam logic [IDX_W-1:0] DATA_BEG  = IDX_W'(2 * SYNC_HALVES);
  localparam logic [IDX_W-1:0] PAR_BEG   = IDX_W'(2 * SYNC_HALVES + 2 * DATA_W);
  localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(FRAME_HALVES - 1);

  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  hidx;
  logic              running, par_q, cmd_q, lvl;

  wire in_data = (hidx >= DATA_BEG) && (hidx < PAR_BEG);

  always_comb begin
    if (hidx < SYNC_MID)      lvl = cmd_q;
    else if (hidx < DATA_BEG) lvl = ~cmd_q;
    else if (in_data)         lvl = hidx[0] ? ~sh_q[DATA_W-1] : sh_q[DATA_W-1];
    else                      lvl = hidx[0] ? ~par_q : par_q;
  end

  assign line = running & lvl;

  always_ff @(posedge clk) begin
    if (master_rst) begin
      busy    <= 1'b0;
      running <= 1'b0;
      done    <= 1'b0;
      hidx    <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      cmd_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && load) begin
        busy    <= 1'b1;
        running <= 1'b0;
        hidx    <= '0;
        sh_q    <= data_in;
        par_q   <= ~^data_in;
        cmd_q   <= sync_cmd;
      end else if (busy && half_tick) begin
        if (!running) begin
          running <= 1'b1;
        end else if (hidx == LAST_HALF) begin
          busy    <= 1'b0;
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          hidx <= hidx + 1'b1;
          if (in_data && hidx[0]) sh_q <= sh_q << 1;
        end
      end
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (master_rst)
    !busy |-> !line);
  assert_busy_on_load_R2: assert property (@(posedge clk) disable iff (master_rst)
    (load && !busy) |=> busy);
  assert_done_end_R7: assert property (@(posedge clk) disable iff (master_rst)
    done |-> (!busy && !$past(done)));
  assert_load_ignored_R8: assert property (@(posedge clk) disable iff (master_rst)
    (busy && load) |=> $stable(cmd_q) && $stable(par_q));
  assert_midbit_edge_R9: assert property (@(posedge clk) disable iff (master_rst)
    (running && half_tick && in_data && !hidx[0]) |=> (line != $past(line)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (master_rst)
    (busy && !half_tick && !load) |=> ($stable(line) && busy));
endmodule

// File: tb/manch_frame_tx_tb.sv
module manch_frame_tx_tb;
  logic clk = 1'b0;
  logic master_rst = 1'b1, half_tick = 1'b0, load = 1'b0, sync_cmd = 1'b0;
  logic [15:0] data_in = '0;
  logic line, busy, done;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  manch_frame_tx u_dut (.clk(clk), .master_rst(master_rst), .half_tick(half_tick),
    .load(load), .data_in(data_in), .sync_cmd(sync_cmd),
    .line(line), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_half(input logic [15:0] w, input logic c, input int h);
    logic b;
    if (h < 3) return c;
    if (h < 6) return ~c;
    if (h < 38) b = w[15 - (h - 6) / 2];
    else        b = ~^w;
    return (h % 2 == 0) ? b : ~b;
  endfunction

  function automatic string tag_of(input logic c, input int h);
    if (h < 6)  return c ? "R3" : "R4";
    if (h < 38) return "R5";
    return "R6";
  endfunction

  task automatic tick();
    @(negedge clk) half_tick = 1'b1;
    @(negedge clk) half_tick = 1'b0;
  endtask

  task automatic start(input logic [15:0] w, input logic c);
    @(negedge clk) begin load = 1'b1; data_in = w; sync_cmd = c; end
    @(negedge clk) load = 1'b0;
    check(busy === 1'b1, "R2", busy, 1);
    check(line === 1'b0, "R2", line, 0);
  endtask

  task automatic finish_frame();
    tick();
    check(done === 1'b1 && busy === 1'b0, "R7", {done, busy}, 2);
    check(line === 1'b0, "R1", line, 0);
    @(negedge clk);
    check(done === 1'b0, "R7", done, 0);
  endtask

  task automatic test_frame(input logic [15:0] w, input logic c);
    start(w, c);
    for (int h = 0; h < 40; h++) begin
      tick();
      check(line === exp_half(w, c, h), tag_of(c, h), line, exp_half(w, c, h));
      check(busy === 1'b1, "R7", busy, 1);
    end
    finish_frame();
  endtask

  task automatic test_load_while_busy();
    start(16'h3C96, 1'b1);
    for (int h = 0; h < 40; h++) begin
      tick();
      if (h == 10) begin
        @(negedge clk) begin load = 1'b1; data_in = 16'hC369; sync_cmd = 1'b0; end
        @(negedge clk) load = 1'b0;
      end
      check(line === exp_half(16'h3C96, 1'b1, h), "R8", line, exp_half(16'h3C96, 1'b1, h));
    end
    finish_frame();
  endtask

  task automatic test_hold();
    logic held;
    start(16'h8001, 1'b0);
    for (int h = 0; h < 9; h++) tick();
    held = line;
    check(held === exp_half(16'h8001, 1'b0, 8), "R10", held, exp_half(16'h8001, 1'b0, 8));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(line === held && busy === 1'b1, "R10", line, held);
    end
    for (int h = 9; h < 40; h++) tick();
    finish_frame();
  endtask

  task automatic test_reset_mid();
    start(16'hFFFF, 1'b1);
    for (int h = 0; h < 12; h++) tick();
    @(negedge clk) master_rst = 1'b1;
    @(negedge clk) master_rst = 1'b0;
    check(line === 1'b0 && busy === 1'b0 && done === 1'b0, "R11", {line, busy, done}, 0);
    tick();
    check(line === 1'b0 && busy === 1'b0, "R11", {line, busy}, 0);
    test_frame(16'h1234, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    master_rst = 1'b0;
    @(negedge clk);
    check(line === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", {line, busy, done}, 0);
    tick();
    check(line === 1'b0 && busy === 1'b0, "R1", {line, busy}, 0);
    test_frame(16'hA5C3, 1'b1);
    test_frame(16'h0000, 1'b0);
    test_frame(16'hFFFF, 1'b0);
    test_frame(16'h0001, 1'b1);
    test_load_while_busy();
    test_hold();
    test_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule